// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing half of a small serial nonvolatile memory. It runs on a fast system clock and oversamples the two bus lines. Each line passes through a two-stage synchronizer and a majority vote. The block then detects start and stop conditions and the clock edges, shifts bytes in and out MSB first, and acknowledges by pulling SDA low through an open-drain output enable.

The first byte after a start selects the device. It carries a fixed type nibble, strap-matched select bits, one page bit that becomes the top bit of the word address, and the read/write flag. The block keeps its own word-address counter and supports these transfers:
- byte and page writes, which roll over inside a 16-byte page;
- current-address reads;
- random reads, made of a dummy write and a repeated start;
- sequential reads, which wrap across the whole array.

Each received data byte goes out on a write-engine strobe. A stop that ends a write carries a commit pulse. While the write engine reports busy, device bytes are not acknowledged, so a host can poll for the end of the write.

Top module: `eeprom_bus_slave`

## Requirements
- R1: While and after reset, with the bus idle, sda_oe, wr_valid and wr_commit are 0 and mem_rd_addr is 0.
- R2: Bits are taken on SCL rising edges, MSB first. sda_oe changes only while the filtered SCL is low, so a read bit holds steady for the whole SCL high phase.
- R3: A device byte is acknowledged when bits 7..4 are 1010, bits 3..2 equal dev_sel, and busy is 0. Bit 1 is the page bit and bit 0 is the direction (1 = read). On a read the page bit is ignored.
- R4: A device byte that does not match gets no acknowledge. The bytes that follow it, up to the next start, produce no acknowledge, no write strobe and no commit, and they leave the address counter unchanged.
- R5: In a write, the byte after the device byte sets word-address bits 7..0, and the page bit sets bit 8. Every later byte is acknowledged and produces one wr_valid pulse carrying the current address and the byte.
- R6: If busy is 1 when a device byte completes, the block does not acknowledge and stays silent until the next start.
- R7: After each written byte, only address bits 3..0 advance, wrapping inside the 16-byte page. Bits 8..4 stay fixed, so more than 16 bytes overwrite earlier ones.
- R8: A stop produces one single-cycle wr_commit pulse if at least one data byte was written since the last start, and no pulse otherwise.
- R9: A start or stop at any bit position abandons the byte in progress. After a start, the next 8 bits are a new device byte.
- R10: A current-address read returns the byte at the counter. The counter equals the last address read plus one, or the last address written plus one inside its page.
- R11: A dummy write of a device byte and an address byte, followed by a repeated start with a read device byte, returns the byte at the loaded address.
- R12: While the host acknowledges, a read continues at the next address, wrapping from 511 to 0. A host no-acknowledge ends the transfer and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| dev_sel | input | 11-ADDR_W (2) | Strap value matched against device byte bits 3..2 |
| busy | input | 1 | Write engine is in its internal write cycle |
| mem_rd_addr | output | ADDR_W (9) | Word-address counter, used as the memory read address |
| mem_rd_data | input | 8 | Memory byte at mem_rd_addr, combinational |
| wr_valid | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | ADDR_W (9) | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse at a stop that ends a write with data |

## Verification
The assertions assume that both bus lines hold each level for longer than the synchronizer and filter latency. They also assume that SDA moves only while SCL is low, except for starts and stops. The write engine raises busy only after a commit, and the memory answers the read address in the same cycle. The bench drives the bus in quarter-bit phases of eight clocks. It models SDA as the wired AND of the host and the block, changes host SDA only in SCL low phases, and starts each transaction only once busy has dropped, except for the deliberate polling check.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_PEND,
        ST_ACK_DRV,
        ST_TX,
        ST_TX_ACK,
        ST_TX_LOAD
    } slv_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } rx_kind_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         BYTE_W   = 8;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int LINES = 2,
    parameter int TAPS  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);

    localparam int HALF = TAPS / 2;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]      sync_d, sync_q;
        logic [TAPS-1:0] hist_d, hist_q;
        logic            out_d, out_q;

        always_comb begin
            int ones;
            ones   = 0;
            sync_d = {sync_q[0], raw[g]};
            hist_d = {hist_q[TAPS-2:0], sync_q[1]};
            for (int i = 0; i < TAPS; i++) begin
                ones = ones + int'(hist_q[i]);
            end
            out_d = (ones > HALF);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '1;
                hist_q <= '1;
                out_q  <= 1'b1;
            end else begin
                sync_q <= sync_d;
                hist_q <= hist_d;
                out_q  <= out_d;
            end
        end

        assign clean[g] = out_q;
    end

endmodule

// File: rtl/bus_events.sv
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d = scl_f;
        sda_prev_d = sda_f;
        start_evt  = scl_prev_q & scl_f & sda_prev_q & ~sda_f;
        stop_evt   = scl_prev_q & scl_f & ~sda_prev_q & sda_f;
        scl_rise   = ~scl_prev_q & scl_f;
        scl_fall   = scl_prev_q & ~scl_f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

endmodule

// File: rtl/slave_fsm.sv
module slave_fsm
    import eeprom_slave_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_evt,
    input  logic                 stop_evt,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 scl_lvl,
    input  logic                 sda_lvl,
    input  logic [10-ADDR_W:0]   dev_sel,
    input  logic                 busy,
    input  logic [BYTE_W-1:0]    mem_rd_data,
    output logic                 sda_oe,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    output logic                 wr_valid,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [BYTE_W-1:0]    wr_data,
    output logic                 wr_commit
);

    localparam int PBITS = ADDR_W - BYTE_W;

    typedef struct packed {
        slv_state_e          state;
        rx_kind_e            kind;
        logic [2:0]          bits;
        logic [BYTE_W-1:0]   sh;
        logic [ADDR_W-1:0]   addr;
        logic [PBITS-1:0]    pg;
        logic                ack_oe;
        logic                rd;
        logic                wrote;
        logic                wv;
        logic [ADDR_W-1:0]   wa;
        logic [BYTE_W-1:0]   wd;
        logic                commit;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [BYTE_W-1:0] rx_byte;
    logic              dev_hit;

    always_comb begin
        r_d       = r_q;
        r_d.wv    = 1'b0;
        r_d.commit = 1'b0;
        rx_byte   = {r_q.sh[BYTE_W-2:0], sda_lvl};
        dev_hit   = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:PBITS+1] == dev_sel) && !busy;

        if (stop_evt) begin
            r_d.commit = r_q.wrote;
            r_d.wrote  = 1'b0;
            r_d.state  = ST_IDLE;
            r_d.ack_oe = 1'b0;
            r_d.bits   = '0;
        end else if (start_evt) begin
            r_d.state  = ST_RX;
            r_d.kind   = K_DEV;
            r_d.bits   = '0;
            r_d.ack_oe = 1'b0;
            r_d.wrote  = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh   = rx_byte;
                        r_d.bits = r_q.bits + 3'd1;
                        if (r_q.bits == 3'd7) begin
                            unique case (r_q.kind)
                                K_DEV: begin
                                    if (dev_hit) begin
                                        r_d.rd    = rx_byte[0];
                                        r_d.pg    = rx_byte[PBITS:1];
                                        r_d.state = ST_ACK_PEND;
                                    end else begin
                                        r_d.state = ST_IDLE;
                                    end
                                end
                                K_WADDR: begin
                                    r_d.addr  = {r_q.pg, rx_byte};
                                    r_d.state = ST_ACK_PEND;
                                end
                                K_WDATA: begin
                                    r_d.wv    = 1'b1;
                                    r_d.wa    = r_q.addr;
                                    r_d.wd    = rx_byte;
                                    r_d.addr[PAGE_W-1:0] = r_q.addr[PAGE_W-1:0] + 1'b1;
                                    r_d.wrote = 1'b1;
                                    r_d.state = ST_ACK_PEND;
                                end
                                default: r_d.state = ST_IDLE;
                            endcase
                        end
                    end
                end
                ST_ACK_PEND: begin
                    if (scl_fall) begin
                        r_d.ack_oe = 1'b1;
                        r_d.state  = ST_ACK_DRV;
                    end
                end
                ST_ACK_DRV: begin
                    if (scl_fall) begin
                        r_d.ack_oe = 1'b0;
                        r_d.bits   = '0;
                        if (r_q.rd) begin
                            r_d.sh    = mem_rd_data;
                            r_d.state = ST_TX;
                        end else begin
                            r_d.state = ST_RX;
                            r_d.kind  = (r_q.kind == K_DEV) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.bits == 3'd7) begin
                            r_d.state = ST_TX_ACK;
                        end else begin
                            r_d.bits = r_q.bits + 3'd1;
                            r_d.sh   = {r_q.sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.state = sda_lvl ? ST_IDLE : ST_TX_LOAD;
                    end
                end
                ST_TX_LOAD: begin
                    if (scl_fall) begin
                        r_d.bits  = '0;
                        r_d.sh    = mem_rd_data;
                        r_d.state = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe      = r_q.ack_oe | ((r_q.state == ST_TX) & ~r_q.sh[BYTE_W-1]);
    assign mem_rd_addr = r_q.addr;
    assign wr_valid    = r_q.wv;
    assign wr_addr     = r_q.wa;
    assign wr_data     = r_q.wd;
    assign wr_commit   = r_q.commit;

    // R2: the data line driver moves only during the low phase of SCL
    a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R4: SDA is pulled only in an acknowledge slot or while sending a byte
    a_r4_oe_only_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (r_q.state == ST_ACK_DRV || r_q.state == ST_TX));

    // R6: a device byte completing under busy leads to silence
    a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RX && r_q.kind == K_DEV && r_q.bits == 3'd7 && scl_rise
         && busy && !start_evt && !stop_evt) |=> r_q.state == ST_IDLE);

    // R7: a strobed write stays inside the page held by the counter
    a_r7_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wv |-> r_q.wa[ADDR_W-1:PAGE_W] == r_q.addr[ADDR_W-1:PAGE_W]);

    // R8: commit lasts a single cycle
    a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // R9: a start begins a fresh device byte at bit zero
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (r_q.state == ST_RX && r_q.kind == K_DEV && r_q.bits == 3'd0));

endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave #(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int FILT_TAPS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_oe,
    input  logic [10-ADDR_W:0]  dev_sel,
    input  logic                busy,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic [7:0]          mem_rd_data,
    output logic                wr_valid,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [7:0]          wr_data,
    output logic                wr_commit
);

    logic [1:0] lines_clean;
    logic       scl_f, sda_f;
    logic       start_evt, stop_evt, scl_rise, scl_fall;

    line_filter #(
        .LINES (2),
        .TAPS  (FILT_TAPS)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_in, scl_in}),
        .clean (lines_clean)
    );

    assign scl_f = lines_clean[0];
    assign sda_f = lines_clean[1];

    bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    slave_fsm #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .scl_lvl     (scl_f),
        .sda_lvl     (sda_f),
        .dev_sel     (dev_sel),
        .busy        (busy),
        .mem_rd_data (mem_rd_data),
        .sda_oe      (sda_oe),
        .mem_rd_addr (mem_rd_addr),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_commit   (wr_commit)
    );

endmodule

// File: tb/eeprom_bus_slave_test.sv
module eeprom_bus_slave_test;

    localparam int ADDR_W   = 9;
    localparam int PAGE_W   = 4;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE     = 1 << PAGE_W;
    localparam int Q        = 8;
    localparam int BUSY_CYC = 600;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              m_scl = 1'b1;
    logic              m_sda = 1'b1;
    logic [1:0]        dev_sel = 2'b10;
    logic              busy;
    logic              sda_oe;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [7:0]        mem_rd_data;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              wr_commit;
    wire               sda_line = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    eeprom_bus_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (m_scl),
        .sda_in      (sda_line),
        .sda_oe      (sda_oe),
        .dev_sel     (dev_sel),
        .busy        (busy),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_commit   (wr_commit)
    );

    // memory array and write-engine model
    logic [7:0]        mem [DEPTH];
    logic [7:0]        exp_mem [DEPTH];
    logic [ADDR_W-1:0] cap_addr [1024];
    logic [7:0]        cap_data [1024];
    logic [ADDR_W-1:0] pend_a [64];
    logic [7:0]        pend_d [64];
    int                cap_n = 0;
    int                pend_n = 0;
    int                commit_n = 0;
    int                busy_cnt = 0;
    bit                init_done = 1'b0;
    int                checks = 0;
    int                errors = 0;
    int                ptr = 0;

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    function automatic int page_next(input int a, input int i);
        return (a & ~(PAGE - 1)) | ((a + i) & (PAGE - 1));
    endfunction

    function automatic logic [7:0] dev_byte(input bit rw, input bit pg);
        return {4'b1010, dev_sel, pg, rw};
    endfunction

    assign mem_rd_data = mem[mem_rd_addr];
    assign busy        = (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt = 0;
            pend_n   = 0;
            if (!init_done) begin
                for (int i = 0; i < DEPTH; i++) mem[i] = init_val(i);
                init_done = 1'b1;
            end
        end else begin
            if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
            if (wr_valid) begin
                if (cap_n < 1024) begin
                    cap_addr[cap_n] = wr_addr;
                    cap_data[cap_n] = wr_data;
                end
                cap_n = cap_n + 1;
                if (pend_n < 64) begin
                    pend_a[pend_n] = wr_addr;
                    pend_d[pend_n] = wr_data;
                    pend_n = pend_n + 1;
                end
            end
            if (wr_commit) begin
                for (int i = 0; i < pend_n; i++) mem[pend_a[i]] = pend_d[i];
                pend_n   = 0;
                commit_n = commit_n + 1;
                busy_cnt = BUSY_CYC;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i >= 8 - nb; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b, output bit steady);
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q - 1);
            if (sda_line !== b[i]) steady = 1'b0;
            tick(1);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~mack; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic wait_ready();
        while (busy) tick(1);
        tick(4);
    endtask

    task automatic read_burst(input int start_a, input int k, input string tag);
        logic [7:0] b;
        bit steady;
        for (int i = 0; i < k; i++) begin
            recv_byte(i != k - 1, b, steady);
            check(b == exp_mem[(start_a + i) % DEPTH], tag, b, exp_mem[(start_a + i) % DEPTH]);
            check(steady, "R2 read bit steady while SCL high", steady, 1);
        end
        bus_stop();
        ptr = (start_a + k) % DEPTH;
    endtask

    task automatic page_write(input int a, input int n);
        logic [7:0] d [32];
        bit ack;
        int base, cb;
        wait_ready();
        base = cap_n;
        cb   = commit_n;
        bus_start();
        send_byte(dev_byte(1'b0, a[8]), ack);
        check(ack, "R3 write device byte acknowledged", ack, 1);
        send_byte(a[7:0], ack);
        check(ack, "R5 word address acknowledged", ack, 1);
        for (int i = 0; i < n; i++) begin
            d[i] = 8'($urandom);
            send_byte(d[i], ack);
            check(ack, "R5 data byte acknowledged", ack, 1);
        end
        bus_stop();
        tick(Q);
        check(cap_n - base == n, "R5 one strobe per data byte", cap_n - base, n);
        for (int i = 0; i < n && base + i < 1024; i++) begin
            check(cap_addr[base + i] == page_next(a, i), "R7 in-page address roll",
                  cap_addr[base + i], page_next(a, i));
            check(cap_data[base + i] == d[i], "R5 strobed data", cap_data[base + i], d[i]);
        end
        check(commit_n - cb == ((n > 0) ? 1 : 0), "R8 commit at stop", commit_n - cb, (n > 0) ? 1 : 0);
        for (int i = 0; i < n; i++) exp_mem[page_next(a, i)] = d[i];
        ptr = page_next(a, n);
    endtask

    task automatic rand_read(input int a, input int k, input string tag);
        bit ack;
        wait_ready();
        bus_start();
        send_byte(dev_byte(1'b0, a[8]), ack);
        check(ack, "R11 dummy write device ack", ack, 1);
        send_byte(a[7:0], ack);
        check(ack, "R11 dummy write address ack", ack, 1);
        bus_start();
        send_byte(dev_byte(1'b1, 1'b0), ack);
        check(ack, "R3 read device byte acknowledged", ack, 1);
        read_burst(a, k, tag);
    endtask

    task automatic cur_read(input int k, input bit pg, input string tag);
        bit ack;
        wait_ready();
        bus_start();
        send_byte(dev_byte(1'b1, pg), ack);
        check(ack, "R3 read device byte acknowledged", ack, 1);
        read_burst(ptr, k, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished run");
        $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        bit ack;
        int base, cb;
        void'($urandom(32'd71523));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_val(i);
        rst_n = 1'b0;
        tick(6);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        check(wr_valid == 1'b0, "R1 wr_valid after reset", wr_valid, 0);
        check(wr_commit == 1'b0, "R1 wr_commit after reset", wr_commit, 0);
        check(mem_rd_addr == 0, "R1 address counter after reset", mem_rd_addr, 0);

        // R10 first current-address read starts at 0
        cur_read(2, 1'b0, "R10 current read after reset");

        // R7 overlong page write wraps and overwrites
        page_write(9'h1F3, 20);

        // R6 polling while busy, then acknowledged once idle
        base = cap_n;
        cb   = commit_n;
        bus_start();
        send_byte(dev_byte(1'b0, 1'b0), ack);
        check(!ack && busy, "R6 no ack while busy", ack, 0);
        bus_stop();
        wait_ready();
        bus_start();
        send_byte(dev_byte(1'b0, 1'b0), ack);
        check(ack, "R6 ack after busy clears", ack, 1);
        bus_stop();
        tick(Q);
        check(commit_n == cb, "R8 no commit without data", commit_n - cb, 0);
        check(cap_n == base, "R6 no strobes from polling", cap_n - base, 0);

        // R10 current read after write
        cur_read(1, 1'b0, "R10 read at last written plus one");
        page_write(9'h1FC, 6);
        cur_read(1, 1'b0, "R10 counter wraps inside page after write");

        // R4 mismatching device bytes
        wait_ready();
        base = cap_n;
        cb   = commit_n;
        bus_start();
        send_byte({4'b1010, ~dev_sel, 2'b00}, ack);
        check(!ack, "R4 wrong strap no ack", ack, 0);
        send_byte(8'h10, ack);
        check(!ack, "R4 following byte ignored", ack, 0);
        send_byte(8'h5A, ack);
        check(!ack, "R4 following data ignored", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, dev_sel, 2'b00}, ack);
        check(!ack, "R4 wrong type nibble no ack", ack, 0);
        bus_stop();
        tick(Q);
        check(cap_n == base, "R4 no strobe after mismatch", cap_n - base, 0);
        check(commit_n == cb, "R4 no commit after mismatch", commit_n - cb, 0);
        cur_read(1, 1'b0, "R4 counter unchanged after mismatch");

        // R9 start in the middle of a device byte
        wait_ready();
        bus_start();
        send_bits(dev_byte(1'b1, 1'b0), 3);
        cur_read(1, 1'b0, "R9 restart mid-byte");

        // R9 stop in the middle of the address byte
        wait_ready();
        base = cap_n;
        cb   = commit_n;
        bus_start();
        send_byte(dev_byte(1'b0, ~ptr[8]), ack);
        check(ack, "R9 device ack before abort", ack, 1);
        send_bits(8'hA5, 4);
        bus_stop();
        tick(Q);
        check(cap_n == base && commit_n == cb, "R9 aborted byte writes nothing",
              cap_n - base + commit_n - cb, 0);
        cur_read(1, 1'b0, "R9 counter unchanged by aborted address");

        // R12 sequential read across the top of the array
        rand_read(DEPTH - 3, 6, "R12 sequential wrap 511 to 0");
        cur_read(2, 1'b1, "R3 page bit ignored on read");

        // random writes and reads
        for (int it = 0; it < 5; it++) begin
            int a, n;
            a = int'($urandom_range(DEPTH - 1, 0));
            n = int'($urandom_range(18, 1));
            page_write(a, n);
            cur_read(1, 1'b0, "R10 current read after random write");
            rand_read(int'($urandom_range(DEPTH - 1, 0)), int'($urandom_range(3, 1)), "R11 random read");
            rand_read(a & ~(PAGE - 1), PAGE, "R12 sequential page readback");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule